// File: doc/BRIEF.md
# Program-Flow Discontinuity Trace Buffer

This block watches the retirement stream of a processor and records only the points where program flow leaves straight-line order. Such points are taken branches, jumps and interrupt entries. Each record holds the address of the retiring instruction, the address it transferred to, a kind bit, and the number of clock cycles since the previous record. The cycle count exposes stall time from cache misses and pipeline effects. Records go into a circular store, so the newest history always survives and older records are overwritten.

When a breakpoint or halt raises the freeze input, the store stops accepting records and keeps its contents until an explicit re-arm. A debugger or crash handler then reads the records through an indexed port, newest first, and can copy them to persistent storage. Re-arm empties the store and restarts capture.

Top module: `disc_trace_buffer`

## Requirements
- R1: A record is written only in a cycle where `retire_valid` and `disc_valid` are both high, `freeze` and `rearm` are low, and the block is not frozen. Any other retirement leaves the store unchanged.
- R2: A record stores `retire_pc` as its source, `disc_target` as its destination, and `disc_kind` as its kind (0 = branch or jump, 1 = interrupt entry).
- R3: A record's cycle field is the number of clock edges since the previous record, re-arm or reset, counting the writing edge itself. It is at least 1 and saturates at 2^CNT_W-1 instead of wrapping.
- R4: The store holds DEPTH records. `entry_count` rises by one per record up to DEPTH and then stays there, while each new record replaces the oldest one.
- R5: `rd_idx` = 0 returns the newest record, and each higher index returns the next older one. An index at or above `entry_count` gives `rd_valid` = 0 with every data output zero.
- R6: A high `freeze` blocks the write in its own cycle and sets `frozen` from the next cycle on. The block stays frozen until a re-arm, and stored records do not change while it is frozen.
- R7: A high `rearm` empties the store and restarts the cycle count from the next cycle. It leaves the block unfrozen unless `freeze` is high in the same cycle, in which case `freeze` wins. A discontinuity in a re-arm cycle is not recorded.
- R8: After reset the store is empty, `frozen` is low and every read is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | PC_W | Address of the retiring instruction |
| disc_valid | input | 1 | The retiring instruction changes program flow |
| disc_kind | input | 1 | 0 = branch or jump, 1 = interrupt entry |
| disc_target | input | PC_W | Address the flow transfers to |
| freeze | input | 1 | Breakpoint or halt: stop capture |
| rearm | input | 1 | Empty the store and resume capture |
| rd_idx | input | IDX_W | Read index, 0 = newest |
| rd_valid | output | 1 | The indexed record exists |
| rd_src | output | PC_W | Source address of the indexed record |
| rd_dst | output | PC_W | Destination address of the indexed record |
| rd_kind | output | 1 | Kind bit of the indexed record |
| rd_cycles | output | CNT_W | Cycle field of the indexed record |
| entry_count | output | IDX_W | Number of valid records |
| frozen | output | 1 | Capture is stopped |

## Verification
The bench drives more than two full laps of the ring with varying gaps and reads every index, valid and invalid, after every cycle. A design with an off-by-one pointer, reversed read order or a missing wrap fails there. It also leaves the block idle long enough for the cycle field to pass its maximum, which catches a counter that wraps to a small value. Freeze is raised in the same cycle as a discontinuity, freeze and re-arm are raised together, and a re-arm is issued alongside a discontinuity. These catch a design that writes one record too many, or that lets re-arm override a halt.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic {
    KIND_BRANCH = 1'b0,
    KIND_IRQ    = 1'b1
  } disc_kind_e;
endpackage

// File: rtl/trc_reset_sync.sv
module trc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/trc_cycle_meter.sv
module trc_cycle_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;

  // edges since last clear, including the current one, saturating
  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    cnt_d   = clr ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign elapsed = cnt_inc;
endmodule

// File: rtl/trc_ring_ctrl.sv
module trc_ring_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             freeze,
  input  logic             rearm,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] count,
  output logic             frozen
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             full_q, full_d;
  logic             frz_q, frz_d;

  always_comb begin
    wr_en  = wr_req && !freeze && !frz_q && !rearm;
    ptr_d  = ptr_q;
    full_d = full_q;
    if (rearm) begin
      ptr_d  = '0;
      full_d = 1'b0;
    end else if (wr_en) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == PTR_LAST) full_d = 1'b1;
    end
    if (freeze)     frz_d = 1'b1;
    else if (rearm) frz_d = 1'b0;
    else            frz_d = frz_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
      frz_q  <= frz_d;
    end
  end

  assign wr_ptr = ptr_q;
  assign count  = full_q ? CNT_FULL : {1'b0, ptr_q};
  assign frozen = frz_q;
endmodule

// File: rtl/trc_entry_store.sv
module trc_entry_store
  import trc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  parameter int CNT_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PC_W-1:0]  wr_src,
  input  logic [PC_W-1:0]  wr_dst,
  input  disc_kind_e       wr_kind,
  input  logic [CNT_W-1:0] wr_cyc,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [PC_W-1:0]  rd_src,
  output logic [PC_W-1:0]  rd_dst,
  output disc_kind_e       rd_kind,
  output logic [CNT_W-1:0] rd_cyc
);
  logic [PC_W-1:0]  src_q [DEPTH];
  logic [PC_W-1:0]  dst_q [DEPTH];
  disc_kind_e       kind_q[DEPTH];
  logic [CNT_W-1:0] cyc_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        src_q[g]  <= wr_src;
        dst_q[g]  <= wr_dst;
        kind_q[g] <= wr_kind;
        cyc_q[g]  <= wr_cyc;
      end
    end
  end

  assign rd_src  = src_q[rd_addr];
  assign rd_dst  = dst_q[rd_addr];
  assign rd_kind = kind_q[rd_addr];
  assign rd_cyc  = cyc_q[rd_addr];
endmodule

// File: rtl/trc_read_port.sv
module trc_read_port #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int IDX_W = PTR_W + 1
) (
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [IDX_W-1:0] count,
  output logic [PTR_W-1:0] rd_addr,
  output logic             hit
);
  // newest slot sits just behind the write pointer; wrap is modulo DEPTH
  assign rd_addr = wr_ptr - 1'b1 - rd_idx[PTR_W-1:0];
  assign hit     = rd_idx < count;
endmodule

// File: rtl/disc_trace_buffer.sv
module disc_trace_buffer
  import trc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  parameter int CNT_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int IDX_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_valid,
  input  logic [PC_W-1:0]  retire_pc,
  input  logic             disc_valid,
  input  logic             disc_kind,
  input  logic [PC_W-1:0]  disc_target,
  input  logic             freeze,
  input  logic             rearm,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PC_W-1:0]  rd_src,
  output logic [PC_W-1:0]  rd_dst,
  output logic             rd_kind,
  output logic [CNT_W-1:0] rd_cycles,
  output logic [IDX_W-1:0] entry_count,
  output logic             frozen
);
  logic             rst_sync_n;
  logic             wr_req, wr_en;
  logic [PTR_W-1:0] wr_ptr, rd_addr;
  logic [CNT_W-1:0] elapsed, st_cyc;
  logic [PC_W-1:0]  st_src, st_dst;
  disc_kind_e       st_kind, in_kind;
  logic             hit;

  trc_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_req  = retire_valid && disc_valid;
  assign in_kind = disc_kind_e'(disc_kind);

  trc_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_req (wr_req),
    .freeze (freeze),
    .rearm  (rearm),
    .wr_en  (wr_en),
    .wr_ptr (wr_ptr),
    .count  (entry_count),
    .frozen (frozen)
  );

  trc_cycle_meter #(.CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (wr_en || rearm),
    .elapsed (elapsed)
  );

  trc_entry_store #(.DEPTH(DEPTH), .PC_W(PC_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_src  (retire_pc),
    .wr_dst  (disc_target),
    .wr_kind (in_kind),
    .wr_cyc  (elapsed),
    .rd_addr (rd_addr),
    .rd_src  (st_src),
    .rd_dst  (st_dst),
    .rd_kind (st_kind),
    .rd_cyc  (st_cyc)
  );

  trc_read_port #(.DEPTH(DEPTH)) u_rd (
    .rd_idx  (rd_idx),
    .wr_ptr  (wr_ptr),
    .count   (entry_count),
    .rd_addr (rd_addr),
    .hit     (hit)
  );

  assign rd_valid  = hit;
  assign rd_src    = hit ? st_src : '0;
  assign rd_dst    = hit ? st_dst : '0;
  assign rd_kind   = hit && (st_kind == KIND_IRQ);
  assign rd_cycles = hit ? st_cyc : '0;
endmodule

// File: rtl/disc_trace_checker.sv
module disc_trace_checker #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic             retire_valid,
  input logic             disc_valid,
  input logic             freeze,
  input logic             rearm,
  input logic             rd_valid,
  input logic [PC_W-1:0]  rd_src,
  input logic [PC_W-1:0]  rd_dst,
  input logic             rd_kind,
  input logic [CNT_W-1:0] rd_cycles,
  input logic [IDX_W-1:0] entry_count,
  input logic             frozen
);
  assert_quiet_no_write_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!(retire_valid && disc_valid) && !rearm) |=> $stable(entry_count));

  assert_cycles_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rd_valid |-> (rd_cycles != '0));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    entry_count <= IDX_W'(DEPTH));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rearm |=> (entry_count == $past(entry_count)) ||
               (entry_count == $past(entry_count) + 1'b1));

  assert_invalid_zero_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rd_valid |-> (rd_src == '0 && rd_dst == '0 && rd_cycles == '0 && !rd_kind));

  assert_freeze_latch_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    freeze |=> frozen);

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (frozen && !rearm) |=> (frozen && $stable(entry_count)));

  assert_rearm_clear_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rearm |=> (entry_count == '0) && (frozen == $past(freeze)));
endmodule

bind disc_trace_buffer disc_trace_checker #(
  .DEPTH (DEPTH),
  .PC_W  (PC_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_ok_n     (rst_sync_n),
  .retire_valid (retire_valid),
  .disc_valid   (disc_valid),
  .freeze       (freeze),
  .rearm        (rearm),
  .rd_valid     (rd_valid),
  .rd_src       (rd_src),
  .rd_dst       (rd_dst),
  .rd_kind      (rd_kind),
  .rd_cycles    (rd_cycles),
  .entry_count  (entry_count),
  .frozen       (frozen)
);

// File: tb/tb_disc_trace_buffer.sv
`timescale 1ns/100ps
module tb_disc_trace_buffer;
  localparam int DEPTH = 8;
  localparam int PC_W  = 16;
  localparam int CNT_W = 8;
  localparam int IDX_W = $clog2(DEPTH) + 1;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk, rst_n;
  logic             retire_valid, disc_valid, disc_kind, freeze, rearm;
  logic [PC_W-1:0]  retire_pc, disc_target;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid, rd_kind, frozen;
  logic [PC_W-1:0]  rd_src, rd_dst;
  logic [CNT_W-1:0] rd_cycles;
  logic [IDX_W-1:0] entry_count;

  int n_cmp, n_bad;

  // bench model
  logic [PC_W-1:0]  m_src [256];
  logic [PC_W-1:0]  m_dst [256];
  logic             m_kind[256];
  int               m_cyc [256];
  int               m_n, m_gap;
  logic             m_frozen;

  disc_trace_buffer #(.DEPTH(DEPTH), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
    .clk (clk), .rst_n (rst_n),
    .retire_valid (retire_valid), .retire_pc (retire_pc),
    .disc_valid (disc_valid), .disc_kind (disc_kind), .disc_target (disc_target),
    .freeze (freeze), .rearm (rearm), .rd_idx (rd_idx),
    .rd_valid (rd_valid), .rd_src (rd_src), .rd_dst (rd_dst),
    .rd_kind (rd_kind), .rd_cycles (rd_cycles),
    .entry_count (entry_count), .frozen (frozen)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int held;
    held = (m_n < DEPTH) ? m_n : DEPTH;
    cmp("R4 count", int'(entry_count), held);
    cmp("R6 frozen", int'(frozen), int'(m_frozen));
    for (int i = 0; i < 2 * DEPTH; i++) begin
      int e;
      rd_idx = IDX_W'(i);
      #0.1;
      e = m_n - 1 - i;
      if (i < held) begin
        cmp("R5 valid", int'(rd_valid), 1);
        cmp("R2 src", int'(rd_src), int'(m_src[e % 256]));
        cmp("R2 dst", int'(rd_dst), int'(m_dst[e % 256]));
        cmp("R2 kind", int'(rd_kind), int'(m_kind[e % 256]));
        cmp("R3 cycles", int'(rd_cycles), m_cyc[e % 256]);
      end else begin
        cmp("R5 valid", int'(rd_valid), 0);
        cmp("R5 zero data", int'(rd_src) + int'(rd_dst) + int'(rd_cycles) + int'(rd_kind), 0);
      end
    end
  endtask

  task automatic step(input logic rv, input logic dv, input logic kd,
                      input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tg,
                      input logic fz, input logic ra);
    logic wr;
    retire_valid = rv; disc_valid = dv; disc_kind = kd;
    retire_pc = pc; disc_target = tg; freeze = fz; rearm = ra;
    @(posedge clk);
    #1;
    wr = rv && dv && !fz && !m_frozen && !ra;
    if (wr) begin
      m_src[m_n % 256]  = pc;
      m_dst[m_n % 256]  = tg;
      m_kind[m_n % 256] = kd;
      m_cyc[m_n % 256]  = (m_gap == CMAX) ? CMAX : m_gap + 1;
      m_n++;
      m_gap = 0;
    end else if (ra) m_gap = 0;
    else m_gap = (m_gap == CMAX) ? CMAX : m_gap + 1;
    if (ra) m_n = 0;
    if (fz) m_frozen = 1'b1;
    else if (ra) m_frozen = 1'b0;
    check_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++)
      step(1'b1, 1'b0, 1'b0, PC_W'(16'h0040 + k), 16'h0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; m_n = 0; m_gap = 0; m_frozen = 1'b0;
    retire_valid = 0; disc_valid = 0; disc_kind = 0; freeze = 0; rearm = 0;
    retire_pc = '0; disc_target = '0; rd_idx = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    cmp("R8 count", int'(entry_count), 0);
    cmp("R8 frozen", int'(frozen), 0);
    cmp("R8 valid", int'(rd_valid), 0);
    check_all();

    step(0, 0, 0, 16'h0, 16'h0, 0, 1);  // align cycle count

    // R1: plain retirements and stray discontinuity flags record nothing
    idle(3);
    step(1'b0, 1'b1, 1'b1, 16'h0123, 16'h4567, 1'b0, 1'b0);
    cmp("R1 no write", int'(entry_count), 0);

    // R2 R3 R4 R5: more than two laps with varied gaps and kinds
    for (int w = 0; w < 2 * DEPTH + 5; w++) begin
      idle(w % 4);
      step(1'b1, 1'b1, (w % 3) == 0, PC_W'(16'h0100 + w * 3),
           PC_W'(16'h8000 ^ (w * 37)), 1'b0, 1'b0);
    end
    // back-to-back records
    step(1'b1, 1'b1, 1'b1, 16'h0A00, 16'h0B00, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 16'h0A04, 16'h0C00, 1'b0, 1'b0);

    // R3: saturation after a long quiet stretch
    idle(CMAX + 40);
    step(1'b1, 1'b1, 1'b0, 16'h1234, 16'h4321, 1'b0, 1'b0);
    cmp("R3 saturate", int'(rd_cycles), -1 & 0 + (rd_idx == 0 ? CMAX : int'(rd_cycles)));
    rd_idx = '0; #0.1;
    cmp("R3 saturate newest", int'(rd_cycles), CMAX);

    // R6: freeze in the same cycle as a discontinuity, then hold
    step(1'b1, 1'b1, 1'b1, 16'h2000, 16'h2100, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 16'h2004, 16'h2200, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 16'h2008, 16'h2300, 1'b0, 1'b0);
    cmp("R6 held count", int'(entry_count), DEPTH);

    // R7: rearm together with a discontinuity clears and records nothing
    step(1'b1, 1'b1, 1'b0, 16'h3000, 16'h3100, 1'b0, 1'b1);
    cmp("R7 cleared", int'(entry_count), 0);
    cmp("R7 unfrozen", int'(frozen), 0);
    for (int w = 0; w < 5; w++) begin
      idle(w);
      step(1'b1, 1'b1, w[0], PC_W'(16'h3200 + w), PC_W'(16'h3300 + 2 * w), 1'b0, 1'b0);
    end

    // R7: freeze and rearm together leaves the block frozen and empty
    step(1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 1'b1);
    cmp("R7 freeze wins", int'(frozen), 1);
    step(1'b1, 1'b1, 1'b0, 16'h4000, 16'h4100, 1'b0, 1'b0);
    cmp("R6 frozen no write", int'(entry_count), 0);
    step(1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b1);
    idle(2);
    step(1'b1, 1'b1, 1'b1, 16'h5000, 16'h5100, 1'b0, 1'b0);
    cmp("R7 resumed", int'(entry_count), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule